// File: doc/BRIEF.md
# Null Symbol Frame Sync Conditioner

This block cleans up an active-low frame sync strobe that marks where the null symbol sits in a received broadcast frame. The strobe can come from an on-chip null detector that is looped back through the pins, or from an external detector. An external detector's falling edge can trail the ideal position by as much as 512 samples, so a programmable compensation count absorbs that lag. Once the compensation count runs out, the block issues a single frame-start pulse and moves into symbol processing.

The raw strobe first passes through a two-stage synchronizer. Transitions are recognized only on sample-enable cycles. After the first accepted falling edge, a 40-sample blanking window hides contact-style bounce. While the block is still waiting and compensating, it holds the lock indicator low. In symbol processing it raises the indicator and ignores the strobe completely. A lock-loss input sends the block back to waiting for a fresh edge.

Top module: `nsync_cond`

## Requirements
- R1: After reset, `frame_start` and `sync_lock` are both low.
- R2: `sync_n` passes through two synchronizer flops. A falling edge is recognized only on a cycle with `smp_en` high. While `smp_en` stays low, a fall on `sync_n` causes no pulse, and the fall is recognized on the first enabled cycle afterwards.
- R3: With `smp_en` held high and compensation value D, `frame_start` goes high on the D+4th rising clock edge after `sync_n` falls. This is D+1 samples after the sample on which the edge is recognized.
- R4: A `comp_val` above 512 acts as 512.
- R5: `frame_start` is high for exactly one clock cycle, and only on a cycle that follows an enabled sample.
- R6: While compensating, a falling edge recognized on samples 1 to 40 after the accepted edge is ignored. A falling edge recognized 41 or more samples later restarts both the compensation count and the blanking window from that edge.
- R7: In symbol processing, `sync_lock` is high and `sync_n` has no effect. The block stays in this state until `lock_lost` is asserted.
- R8: `sync_lock` is low throughout null detection, both while waiting for an edge and while compensating.
- R9: When `lock_lost` is high at a clock edge, the block returns to waiting. This clears both counters and cancels any pulse that would have followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | One-cycle strobe per input sample |
| sync_n | input | 1 | Raw active-low null-symbol strobe |
| comp_val | input | CVW (10) | Delay compensation in samples, clamped to 512 |
| lock_lost | input | 1 | Synchronous return to null detection |
| frame_start | output | 1 | Single-cycle frame-start pulse |
| sync_lock | output | 1 | High while in symbol processing |

## Verification
The hardest case to reach from the ports is a restart caused by a late edge: a second fall has to arrive exactly at the blanking boundary while compensation is still counting. The bench gets there with a long compensation value and a scheduled bounce. It raises the strobe partway through the count and drops it again on the 40th or 41st sample after the first edge. It then checks that the pulse keeps the original latency in the first case and moves to a new latency in the second. Cancelling a pending pulse with lock loss, and holding a fall back with sample enable low, are driven in the same scheduled way.

// File: rtl/nsync_pkg.sv
package nsync_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_COMP = 2'd1,
    ST_SYM  = 2'd2
  } nsync_state_e;

  // Limit a requested compensation to the largest supported lag.
  function automatic int unsigned clamp_comp(int unsigned req, int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction
endpackage

// File: rtl/nsync_edge.sv
module nsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic raw_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              synced;

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], raw_n};
      if (smp_en) prev <= synced;
    end
  end

  assign fall = smp_en && prev && !synced;
endmodule

// File: rtl/nsync_dcnt.sv
module nsync_dcnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (load)           cnt <= ld_val;
    else if (dec && !zero)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nsync_cond.sv
module nsync_cond #(
  parameter int CVW         = 10,
  parameter int MAX_COMP    = 512,
  parameter int JIT_SAMPLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_en,
  input  logic           sync_n,
  input  logic [CVW-1:0] comp_val,
  input  logic           lock_lost,
  output logic           frame_start,
  output logic           sync_lock
);
  import nsync_pkg::*;

  localparam int CW = $clog2(MAX_COMP + 1);
  localparam int JW = $clog2(JIT_SAMPLES + 1);

  nsync_state_e state;
  logic         fall;
  logic         in_comp;
  logic         accept;
  logic         finish;
  logic         step;
  logic [CW-1:0] comp_cnt;
  logic [JW-1:0] jit_cnt;
  logic          comp_zero;
  logic          jit_zero;
  logic [CW-1:0] comp_ld;

  nsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .raw_n(sync_n), .fall(fall)
  );

  assign comp_ld = CW'(clamp_comp(int'(comp_val), MAX_COMP));
  assign in_comp = (state == ST_COMP);
  assign accept  = fall && ((state == ST_WAIT) || (in_comp && jit_zero));
  assign step    = in_comp && smp_en && !accept;
  assign finish  = step && comp_zero;

  nsync_dcnt #(.W(CW)) u_comp (
    .clk(clk), .rst_n(rst_n), .clr(lock_lost), .load(accept),
    .ld_val(comp_ld), .dec(step), .cnt(comp_cnt), .zero(comp_zero)
  );

  nsync_dcnt #(.W(JW)) u_jit (
    .clk(clk), .rst_n(rst_n), .clr(lock_lost), .load(accept),
    .ld_val(JW'(JIT_SAMPLES)), .dec(step), .cnt(jit_cnt), .zero(jit_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_WAIT;
      frame_start <= 1'b0;
    end else begin
      frame_start <= !lock_lost && finish;
      if (lock_lost)   state <= ST_WAIT;
      else if (accept) state <= ST_COMP;
      else if (finish) state <= ST_SYM;
    end
  end

  assign sync_lock = (state == ST_SYM);
endmodule

// File: rtl/nsync_cond_chk.sv
module nsync_cond_chk #(
  parameter int MAX_COMP    = 512,
  parameter int JIT_SAMPLES = 40,
  parameter int CW          = 10,
  parameter int JW          = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_en,
  input logic          lock_lost,
  input logic          frame_start,
  input logic          sync_lock,
  input logic [CW-1:0] comp_cnt,
  input logic [JW-1:0] jit_cnt
);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_pulse_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> !frame_start);

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lock && !lock_lost) |=> sync_lock);

  assert_lock_rises_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_lock) |-> frame_start);

  assert_lock_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> (!sync_lock && !frame_start && comp_cnt == '0 && jit_cnt == '0));

  assert_comp_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    comp_cnt <= CW'(MAX_COMP));

  assert_jit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jit_cnt <= JW'(JIT_SAMPLES));
endmodule

bind nsync_cond nsync_cond_chk #(
  .MAX_COMP(MAX_COMP), .JIT_SAMPLES(JIT_SAMPLES), .CW(CW), .JW(JW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .lock_lost(lock_lost),
  .frame_start(frame_start), .sync_lock(sync_lock),
  .comp_cnt(comp_cnt), .jit_cnt(jit_cnt)
);

// File: tb/tb_nsync_cond.sv
module tb_nsync_cond;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int VEC_D[NVEC]   = '{0, 1, 5, 39, 40, 100, 512, 700};
  localparam int VEC_LAT[NVEC] = '{4, 5, 9, 43, 44, 104, 516, 516};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b1;
  logic       sync_n = 1'b1;
  logic [9:0] comp_val = '0;
  logic       lock_lost = 1'b0;
  logic       frame_start;
  logic       sync_lock;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsync_cond dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_n(sync_n),
    .comp_val(comp_val), .lock_lost(lock_lost),
    .frame_start(frame_start), .sync_lock(sync_lock)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rearm();
    @(negedge clk);
    sync_n = 1'b1;
    lock_lost = 1'b1;
    @(negedge clk);
    lock_lost = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Drop sync_n at a falling clock edge, optionally bounce it, and measure
  // the pulse latency in rising edges, its width and the lock during the wait.
  task automatic run(input int d, input int rise_at, input int fall_at,
                     input int exp_lat, input string req);
    int lat = 0;
    int width = 0;
    int early_lock = 0;
    rearm();
    comp_val = 10'(d);
    sync_n = 1'b0;
    for (int c = 1; c <= 700; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (frame_start) begin
        width++;
        if (lat == 0) lat = c;
      end
      if (lat == 0 && sync_lock) early_lock++;
      if (c == rise_at) sync_n = 1'b1;
      if (c == fall_at) sync_n = 1'b0;
      if (lat != 0 && c >= lat + 3) break;
    end
    check({req, " latency"}, lat, exp_lat);
    check("R5 pulse width", width, 1);
    check("R8 lock low before pulse", early_lock, 0);
    check("R7 lock high after pulse", int'(sync_lock), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pulses;
    int lock_drop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 frame_start after reset", int'(frame_start), 0);
    check("R1 sync_lock after reset", int'(sync_lock), 0);

    // Table of compensation values and latencies (R3, R4 for clamped 700)
    for (int i = 0; i < NVEC; i++) begin
      run(VEC_D[i], 0, 0, VEC_LAT[i], (VEC_D[i] > 512) ? "R4" : "R3");
    end

    // R7: strobe toggles in symbol processing are ignored
    pulses = 0;
    lock_drop = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      sync_n = ((c / 7) % 2) == 0;
      if (frame_start) pulses++;
      if (!sync_lock) lock_drop++;
    end
    check("R7 pulses while locked", pulses, 0);
    check("R7 lock drops while locked", lock_drop, 0);

    // R6: bounce inside the window, on its last sample, and just after it
    run(100, 5, 10, 104, "R6 bounce inside window");
    run(100, 20, 40, 104, "R6 edge on sample 40");
    run(100, 20, 41, 145, "R6 edge on sample 41 restarts");

    // R9: lock loss while compensating cancels the pulse
    rearm();
    comp_val = 10'd100;
    sync_n = 1'b0;
    repeat (20) @(negedge clk);
    lock_lost = 1'b1;
    @(negedge clk);
    lock_lost = 1'b0;
    pulses = 0;
    lock_drop = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (frame_start) pulses++;
      if (sync_lock) lock_drop++;
    end
    check("R9 pulses after lock loss", pulses, 0);
    check("R9 lock after lock loss", lock_drop, 0);
    run(3, 0, 0, 7, "R9 recovery");

    // R9: lock loss from symbol processing drops the lock next cycle
    @(negedge clk);
    lock_lost = 1'b1;
    @(negedge clk);
    lock_lost = 1'b0;
    check("R9 lock dropped", int'(sync_lock), 0);

    // R2: a fall held back by smp_en low, then seen on the first enabled sample
    rearm();
    comp_val = 10'd5;
    smp_en = 1'b0;
    sync_n = 1'b0;
    pulses = 0;
    lock_drop = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (frame_start) pulses++;
      if (sync_lock) lock_drop++;
    end
    check("R2 pulses with smp_en low", pulses, 0);
    check("R2 lock with smp_en low", lock_drop, 0);
    smp_en = 1'b1;
    begin
      int lat = 0;
      for (int c = 1; c <= 30; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (frame_start && lat == 0) lat = c;
      end
      check("R2 latency after enable", lat, 7);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule